// File: doc/BRIEF.md
# Switchable 8/16-bit YCbCr 4:2:2 Output Port Formatter

This block sits between a video processing core and a 16-bit pixel output bus. The core presents 4:2:2 pixel pairs as two luma samples and one Cb/Cr pair. The block serialises each pair onto the bus in one of two layouts. In the narrow layout, the four samples are interleaved on the upper byte, one per sample-clock cycle. In the wide layout, luma occupies the upper byte and chroma the lower byte, and each pixel is held for two cycles. Lanes that the selected layout does not use are put into high impedance through per-lane output enables. A format code that is reserved or not supported disables both lanes.

The block also produces the pixel clock for the downstream device. This clock is either the sample clock itself or a half-rate clock whose high phase covers the luma cycles, and an inversion control can flip it. Format, chroma order, clock select and clock inversion are all sampled on the line-start strobe. A setting change therefore always begins on the first sample of a line, with the sample phase and the clock divider realigned at that point.

The source holds each pair stable for four sample-clock cycles. The first pair of a line is presented in the same cycle as the line-start strobe.

Top module: `pixelPortFormatter`

## Requirements
- R1: After reset the port uses the narrow layout, with the upper lane enabled and the lower lane off (portOe = 2'b10), no chroma swap and a full-rate clock.
- R2: In the narrow layout (fmtSel 4'b0011), the upper byte carries Cb, Y0, Cr, Y1 on four consecutive cycles, starting in the cycle after the line-start edge. The lower lane is disabled and its data is zero.
- R3: In the wide layout (fmtSel 4'b0010), the upper byte carries Y0 for two cycles and then Y1 for two cycles. The lower byte carries Cb alongside Y0 and Cr alongside Y1. Both lanes are enabled (portOe = 2'b11), and the lower lane is never enabled without the upper one.
- R4: When chromaSwap is 1, Cr and Cb exchange their positions in both layouts.
- R5: Every fmtSel code other than 4'b0010 and 4'b0011, including the reserved range 4'b0110 to 4'b1111, disables both lanes (portOe = 2'b00). A lane that is not enabled drives zero data.
- R6: With padSel 3'b000, pixClk follows the sample clock. With padSel 3'b101, pixClk runs at half rate: it is high during the Y0 and Y1 cycles of the narrow sequence (phases 1 and 3) and low during the chroma cycles.
- R7: padSel codes other than 3'b000 and 3'b101 give the full-rate clock.
- R8: When clkInvert is 1, pixClk is inverted in both the full-rate and the half-rate selection.
- R9: Changes on fmtSel, chromaSwap, padSel or clkInvert have no effect until the next line-start strobe. The line-start strobe restarts the four-cycle sample phase at the first sample.
- R10: The wide layout with padSel 3'b000 still gives the full-rate clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock (full rate) |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | First-pair-of-line strobe; also samples the settings |
| pairY0 | input | 8 | First luma sample of the pair |
| pairY1 | input | 8 | Second luma sample of the pair |
| pairCb | input | 8 | Blue-difference chroma of the pair |
| pairCr | input | 8 | Red-difference chroma of the pair |
| fmtSel | input | 4 | Output format code |
| chromaSwap | input | 1 | Exchange Cb and Cr order |
| padSel | input | 3 | Pixel clock select |
| clkInvert | input | 1 | Invert pixel clock |
| portData | output | 16 | Output data bus, upper and lower lanes |
| portOe | output | 2 | Lane enables, bit 1 upper, bit 0 lower |
| pixClk | output | 1 | Output pixel clock |

## Verification
Lines of several pairs with distinct sample values are driven through both layouts, with and without the chroma swap. A Cb/Cr mix-up or a wrong luma position therefore shows up in a specific cycle. Clock checks cover every combination of clock select and inversion, including an unsupported select code and the wide layout at full rate, which separates a divided clock from a pass-through clock. Reserved and unsupported format codes confirm that both lanes go quiet. A line in which the settings change partway through shows that the new settings wait for the next line strobe and do not corrupt the line in flight.

// File: rtl/ppfPkg.sv
`timescale 1ns/1ps
package ppfPkg;

  typedef enum logic [1:0] {
    LAYOUT_NARROW = 2'd0,
    LAYOUT_WIDE   = 2'd1,
    LAYOUT_OFF    = 2'd2
  } layoutE;

  // Strobes from control to datapath
  typedef struct packed {
    logic       loadPair;   // capture the input pair at this edge
    logic [1:0] phase;      // slot within the current pair
    layoutE     layout;     // active layout for this line
    logic       swapChroma; // active chroma order for this line
  } ctrlStrobeT;

endpackage

// File: rtl/ppfCtrl.sv
`timescale 1ns/1ps
module ppfCtrl
  import ppfPkg::*;
#(
  parameter int FMT_W = 4,
  parameter int PAD_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic [FMT_W-1:0] fmtSel,
  input  logic             chromaSwap,
  input  logic [PAD_W-1:0] padSel,
  input  logic             clkInvert,
  output ctrlStrobeT       strobe,
  output logic             pixClk
);

  localparam logic [FMT_W-1:0] CODE_NARROW = FMT_W'(3);
  localparam logic [FMT_W-1:0] CODE_WIDE   = FMT_W'(2);
  localparam logic [PAD_W-1:0] PAD_HALF    = PAD_W'(5);
  localparam int PHASE_W = 2;
  localparam logic [PHASE_W-1:0] LAST_PHASE = '1;

  layoutE             nextLayout;
  layoutE             lineLayout;
  logic               lineSwap;
  logic               lineHalf;
  logic               lineInv;
  logic [PHASE_W-1:0] phase;

  // Format code decode; every unknown code parks the port
  always_comb begin
    unique case (fmtSel)
      CODE_NARROW: nextLayout = LAYOUT_NARROW;
      CODE_WIDE:   nextLayout = LAYOUT_WIDE;
      default:     nextLayout = LAYOUT_OFF;
    endcase
  end

  // Settings are taken only on the line strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineLayout <= LAYOUT_NARROW;
      lineSwap   <= 1'b0;
      lineHalf   <= 1'b0;
      lineInv    <= 1'b0;
    end else if (lineStart) begin
      lineLayout <= nextLayout;
      lineSwap   <= chromaSwap;
      lineHalf   <= (padSel == PAD_HALF);
      lineInv    <= clkInvert;
    end
  end

  // Sample phase, restarted at each line
  always_ff @(posedge clk) begin
    if (!rstN)          phase <= '0;
    else if (lineStart) phase <= '0;
    else                phase <= phase + 1'b1;
  end

  always_comb begin
    strobe.loadPair   = lineStart || (phase == LAST_PHASE);
    strobe.phase      = phase;
    strobe.layout     = lineLayout;
    strobe.swapChroma = lineSwap;
  end

  // Half-rate clock is high on the luma slots (odd phases)
  always_comb begin
    if (lineHalf) pixClk = phase[0] ^ lineInv;
    else          pixClk = clk ^ lineInv;
  end

endmodule

// File: rtl/ppfData.sv
`timescale 1ns/1ps
module ppfData
  import ppfPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobeT          strobe,
  input  logic [DATA_W-1:0]   pairY0,
  input  logic [DATA_W-1:0]   pairY1,
  input  logic [DATA_W-1:0]   pairCb,
  input  logic [DATA_W-1:0]   pairCr,
  output logic [2*DATA_W-1:0] portData,
  output logic [1:0]          portOe
);

  localparam int LANES = 2;
  localparam int HI    = 1;
  localparam int LO    = 0;

  logic [DATA_W-1:0] heldY0, heldY1, heldCb, heldCr;
  logic [DATA_W-1:0] firstC, secondC;
  logic [DATA_W-1:0] laneVal [LANES];
  logic [LANES-1:0]  laneOe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldY0 <= '0;
      heldY1 <= '0;
      heldCb <= '0;
      heldCr <= '0;
    end else if (strobe.loadPair) begin
      heldY0 <= pairY0;
      heldY1 <= pairY1;
      heldCb <= pairCb;
      heldCr <= pairCr;
    end
  end

  assign firstC  = strobe.swapChroma ? heldCr : heldCb;
  assign secondC = strobe.swapChroma ? heldCb : heldCr;

  always_comb begin
    laneVal[HI] = '0;
    laneVal[LO] = '0;
    laneOe      = '0;
    unique case (strobe.layout)
      LAYOUT_NARROW: begin
        laneOe[HI] = 1'b1;
        unique case (strobe.phase)
          2'd0: laneVal[HI] = firstC;
          2'd1: laneVal[HI] = heldY0;
          2'd2: laneVal[HI] = secondC;
          default: laneVal[HI] = heldY1;
        endcase
      end
      LAYOUT_WIDE: begin
        laneOe      = '1;
        laneVal[HI] = strobe.phase[1] ? heldY1 : heldY0;
        laneVal[LO] = strobe.phase[1] ? secondC : firstC;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign portData[g*DATA_W +: DATA_W] = laneOe[g] ? laneVal[g] : '0;
  end
  assign portOe = laneOe;

endmodule

// File: rtl/pixelPortFormatter.sv
`timescale 1ns/1ps
module pixelPortFormatter
  import ppfPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FMT_W  = 4,
  parameter int PAD_W  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineStart,
  input  logic [DATA_W-1:0]   pairY0,
  input  logic [DATA_W-1:0]   pairY1,
  input  logic [DATA_W-1:0]   pairCb,
  input  logic [DATA_W-1:0]   pairCr,
  input  logic [FMT_W-1:0]    fmtSel,
  input  logic                chromaSwap,
  input  logic [PAD_W-1:0]    padSel,
  input  logic                clkInvert,
  output logic [2*DATA_W-1:0] portData,
  output logic [1:0]          portOe,
  output logic                pixClk
);

  ctrlStrobeT ctrlBus;

  ppfCtrl #(.FMT_W(FMT_W), .PAD_W(PAD_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .fmtSel(fmtSel),
    .chromaSwap(chromaSwap), .padSel(padSel), .clkInvert(clkInvert),
    .strobe(ctrlBus), .pixClk(pixClk)
  );

  ppfData #(.DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(ctrlBus),
    .pairY0(pairY0), .pairY1(pairY1), .pairCb(pairCb), .pairCr(pairCr),
    .portData(portData), .portOe(portOe)
  );

endmodule

// File: rtl/ppfChecker.sv
`timescale 1ns/1ps
module ppfChecker #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                lineStart,
  input logic [2*DATA_W-1:0] portData,
  input logic [1:0]          portOe,
  input logic [1:0]          phase
);

  assert_lo_needs_hi_R3: assert property (@(posedge clk) disable iff (!rstN)
    portOe[0] |-> portOe[1]);

  assert_lo_idle_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !portOe[0] |-> (portData[DATA_W-1:0] == '0));

  assert_hi_idle_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !portOe[1] |-> (portData[2*DATA_W-1:DATA_W] == '0));

  assert_layout_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart |=> $stable(portOe));

  assert_phase_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> (phase == 2'd0));

endmodule

bind pixelPortFormatter ppfChecker #(.DATA_W(DATA_W)) i_ppfChecker (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .portData(portData),
  .portOe(portOe), .phase(ctrlBus.phase)
);

// File: tb/test_pixelPortFormatter.sv
`timescale 1ns/1ps
module test_pixelPortFormatter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStart = 1'b0;
  logic [7:0]  pairY0 = '0, pairY1 = '0, pairCb = '0, pairCr = '0;
  logic [3:0]  fmtSel = 4'b0011;
  logic        chromaSwap = 1'b0;
  logic [2:0]  padSel = 3'b000;
  logic        clkInvert = 1'b0;
  logic [15:0] portData;
  logic [1:0]  portOe;
  logic        pixClk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pixelPortFormatter i_pixelPortFormatter (
    .clk(clk), .rstN(rstN), .lineStart(lineStart),
    .pairY0(pairY0), .pairY1(pairY1), .pairCb(pairCb), .pairCr(pairCr),
    .fmtSel(fmtSel), .chromaSwap(chromaSwap), .padSel(padSel),
    .clkInvert(clkInvert), .portData(portData), .portOe(portOe), .pixClk(pixClk)
  );

  task automatic check(string req, logic [18:0] act, logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got oe=%b data=%h clk=%b, expected oe=%b data=%h clk=%b",
               req, act[18:17], act[16:1], act[0], exp[18:17], exp[16:1], exp[0]);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Drive one line of nPairs pairs with the given settings; optionally
  // change the settings at cycle chgAt (they must not apply to this line).
  task automatic runLine(string req, logic [3:0] fmt, bit swap, logic [2:0] pad,
                         bit inv, int nPairs, int seed,
                         int chgAt, logic [3:0] nFmt, bit nSwap,
                         logic [2:0] nPad, bit nInv);
    for (int n = 0; n < 4 * nPairs; n++) begin
      int k;
      int ph;
      logic [7:0] y0, y1, cb, cr, c1, c2, hi, lo;
      logic [1:0] eOe;
      logic eClk;
      k  = seed + n / 4;
      ph = n % 4;
      y0 = 8'(8'h40 + 4 * k);
      y1 = 8'(8'h41 + 4 * k);
      cb = 8'(8'h80 + k);
      cr = 8'(8'hC0 + k);
      @(negedge clk);
      lineStart = (n == 0);
      pairY0 = y0; pairY1 = y1; pairCb = cb; pairCr = cr;
      if (n == 0) begin
        fmtSel = fmt; chromaSwap = swap; padSel = pad; clkInvert = inv;
      end
      if (n == chgAt) begin
        fmtSel = nFmt; chromaSwap = nSwap; padSel = nPad; clkInvert = nInv;
      end
      @(posedge clk);
      #1;
      c1 = swap ? cr : cb;
      c2 = swap ? cb : cr;
      hi = '0; lo = '0; eOe = 2'b00;
      if (fmt == 4'b0011) begin
        eOe = 2'b10;
        case (ph)
          0: hi = c1;
          1: hi = y0;
          2: hi = c2;
          default: hi = y1;
        endcase
      end else if (fmt == 4'b0010) begin
        eOe = 2'b11;
        hi = (ph < 2) ? y0 : y1;
        lo = (ph < 2) ? c1 : c2;
      end
      eClk = (pad == 3'b101) ? ((ph % 2 == 1) ^ inv) : (1'b1 ^ inv);
      check(req, {portOe, portData, pixClk}, {eOe, hi, lo, eClk});
    end
    @(negedge clk);
    lineStart = 1'b0;
  endtask

  task automatic testReset();
    @(posedge clk);
    #1;
    check("R1", {portOe, portData, pixClk}, {2'b10, 16'h0000, 1'b1});
  endtask

  task automatic testNarrow();
    runLine("R2", 4'b0011, 0, 3'b000, 0, 3, 1, -1, 0, 0, 0, 0);
    runLine("R4", 4'b0011, 1, 3'b000, 0, 2, 5, -1, 0, 0, 0, 0);
  endtask

  task automatic testWide();
    runLine("R3", 4'b0010, 0, 3'b101, 0, 3, 9, -1, 0, 0, 0, 0);
    runLine("R4", 4'b0010, 1, 3'b101, 0, 2, 13, -1, 0, 0, 0, 0);
  endtask

  task automatic testReserved();
    runLine("R5", 4'b0110, 0, 3'b000, 0, 1, 20, -1, 0, 0, 0, 0);
    runLine("R5", 4'b1111, 1, 3'b000, 0, 1, 21, -1, 0, 0, 0, 0);
    runLine("R5", 4'b0001, 0, 3'b000, 0, 1, 22, -1, 0, 0, 0, 0);
  endtask

  task automatic testClock();
    runLine("R6", 4'b0011, 0, 3'b101, 0, 2, 30, -1, 0, 0, 0, 0);
    runLine("R7", 4'b0011, 0, 3'b011, 0, 1, 32, -1, 0, 0, 0, 0);
    runLine("R8", 4'b0011, 0, 3'b101, 1, 2, 33, -1, 0, 0, 0, 0);
    runLine("R8", 4'b0011, 0, 3'b000, 1, 1, 35, -1, 0, 0, 0, 0);
    runLine("R10", 4'b0010, 0, 3'b000, 0, 2, 36, -1, 0, 0, 0, 0);
  endtask

  task automatic testMidLine();
    runLine("R9", 4'b0011, 0, 3'b000, 0, 3, 40, 3, 4'b0010, 1, 3'b101, 1);
    runLine("R9", 4'b0010, 1, 3'b101, 1, 2, 44, 2, 4'b0111, 0, 3'b000, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got no completion, expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testNarrow();
    testWide();
    testReserved();
    testClock();
    testMidLine();
    finished = 1;
    summary();
  end

endmodule